// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when a four-bank SDRAM owes an auto-refresh and tells the memory controller. A periodic interval timer, derived at elaboration time from the clock frequency, adds one owed refresh per interval so that 4096 refreshes fit into every 64 ms. The controller may be too busy to refresh at once. Owed refreshes therefore pile up in a bounded backlog of up to eight. When the backlog is full, an urgent flag tells the controller to stop deferring.

The controller precharges all banks, issues an auto-refresh, and pulses an acknowledge. The scheduler then drops one owed refresh and holds its command-legal output low until the refresh cycle time has passed. The scheduler also decides whether a self-refresh entry is accepted. While the memory refreshes itself, no requests are raised. After a self-refresh exit, the exit time plus the refresh cycle time must elapse before the controller may issue anything else.

Top module: `sdram_refresh_scheduler`

## Requirements
- R1: While reset is held, and for the two clocks of synchronous reset release, `ref_req_o`=0, `ref_urgent_o`=0, `backlog_o`=0, `cmd_ok_o`=1 and `self_ref_o`=0.
- R2: In normal mode the backlog grows by one every INTERVAL = floor(CLK_HZ × WINDOW_MS / (1000 × REFRESHES)) clocks. The first increment comes INTERVAL clocks after the first active edge. `ref_req_o` is high exactly when the backlog is nonzero.
- R3: An acknowledge is accepted when `ref_req_o` and `cmd_ok_o` are both high in normal mode. An accepted acknowledge lowers the backlog by one, or leaves it unchanged when an interval ends on the same clock.
- R4: The backlog saturates at BACKLOG_MAX, and interval ends beyond that are dropped. `ref_urgent_o` is high exactly when the backlog equals BACKLOG_MAX.
- R5: An acknowledge has no effect while the backlog is zero or while `cmd_ok_o` is low.
- R6: After an accepted acknowledge, `cmd_ok_o` is low for TRRC_CLKS−1 clocks, where TRRC_CLKS = ceil(TRRC_NS × CLK_HZ / 1e9).
- R7: A self-refresh entry request is accepted only in normal mode with `cmd_ok_o` high. On acceptance the backlog is cleared, `self_ref_o` goes high on the next clock, and the interval timer stops. While `self_ref_o` is high, `ref_req_o` and `cmd_ok_o` stay low.
- R8: An exit request in self-refresh mode returns the block to normal mode on the next clock. `cmd_ok_o` then stays low for TSRE_CLKS+TRRC_CLKS−1 clocks. The interval timer restarts, so the next increment comes INTERVAL clocks after the exit.
- R9: An exit request in normal mode and an entry request in self-refresh mode are ignored.
- R10: When an entry request and an acknowledge are both acceptable on the same clock, the entry wins and the acknowledge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_ack_i | input | 1 | Controller issued one auto-refresh this clock |
| sr_enter_i | input | 1 | Controller asks to enter self-refresh this clock |
| sr_exit_i | input | 1 | Controller raises clock enable to leave self-refresh this clock |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | Backlog is full; refresh must not be deferred further |
| backlog_o | output | $clog2(BACKLOG_MAX+1) | Number of owed refreshes |
| cmd_ok_o | output | 1 | The next command to the memory is legal |
| self_ref_o | output | 1 | Memory is in self-refresh |

## Verification
The bench follows the interval boundary edge by edge. A timer that is off by one lands its first request a clock early or late. It drives the backlog past full: a counter that wraps would show zero where eight is owed, and one that stops short would never raise the urgent flag. It holds the acknowledge high through the refresh-cycle hold and through an empty backlog. A design that accepts acknowledges too early drains the backlog too fast, and one that underflows wraps to fifteen. It also tries entry during the hold, conflicting entry and acknowledge, and exit followed by a timer restart. A design that skips the exit hold, or keeps the timer phase from before entry, shows `cmd_ok_o` or the first request at the wrong clock.

// File: rtl/sdram_refsched_pkg.sv
package sdram_refsched_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SELF = 1'b1
  } rs_mode_e;

  // Clocks per owed refresh, rounded down so the rate never falls short.
  function automatic int unsigned interval_clks(int unsigned hz, int unsigned win_ms,
                                                int unsigned count);
    longint unsigned num;
    num = 64'(hz) * 64'(win_ms);
    return 32'(num / (64'(count) * 64'd1000));
  endfunction

  // Nanoseconds to clocks, rounded up.
  function automatic int unsigned ns_to_clks(int unsigned hz, int unsigned ns);
    longint unsigned num;
    num = 64'(ns) * 64'(hz) + 64'd999_999_999;
    return 32'(num / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
  parameter int unsigned INTERVAL = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic restart,
  output logic tick_o
);
  localparam int unsigned TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    tick_o = run_en && (cnt_q == '0);
    cnt_en = restart || run_en;
    cnt_d  = cnt_q;
    if (restart)     cnt_d = RELOAD;
    else if (tick_o) cnt_d = RELOAD;
    else if (run_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RELOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (INTERVAL > 1) begin : g_spacing
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
      assert_restart_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
  parameter int unsigned MAX = 8,
  localparam int unsigned CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  input  logic          flush,
  output logic [CW-1:0] count_o,
  output logic          pending_o,
  output logic          urgent_o
);
  localparam logic [CW-1:0] FULL = CW'(MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = tick || take || flush;
    cnt_d  = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o   = cnt_q;
  assign pending_o = (cnt_q != '0);
  assign urgent_o  = (cnt_q == FULL);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= FULL);
  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && !flush && urgent_o) |=> urgent_o);
  assert_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && !flush && !urgent_o) |=> (count_o == $past(count_o) + 1'b1));
  assert_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !tick && !flush && pending_o) |=> (count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/refsched_guard.sv
module refsched_guard #(
  parameter int unsigned TRRC_CLKS = 4,
  parameter int unsigned TSRE_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic after_ref,
  input  logic after_wake,
  output logic quiet_o
);
  localparam int unsigned HOLD_MAX = TSRE_CLKS + TRRC_CLKS - 1;
  localparam int unsigned HW = $clog2(HOLD_MAX + 2);
  localparam logic [HW-1:0] REF_LOAD  = HW'(TRRC_CLKS - 1);
  localparam logic [HW-1:0] WAKE_LOAD = HW'(HOLD_MAX);

  logic [HW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    hold_en = after_ref || after_wake || (hold_q != '0);
    hold_d  = hold_q;
    if (after_wake)          hold_d = WAKE_LOAD;
    else if (after_ref)      hold_d = REF_LOAD;
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign quiet_o = (hold_q == '0);

  generate
    if (TRRC_CLKS > 1) begin : g_ref_hold
      assert_trrc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        after_ref |=> !quiet_o);
    end
    if (HOLD_MAX > 0) begin : g_wake_hold
      assert_wake_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        after_wake |=> !quiet_o);
    end
  endgenerate

endmodule

// File: rtl/sdram_refresh_scheduler.sv
module sdram_refresh_scheduler
  import sdram_refsched_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned WINDOW_MS   = 64,
  parameter int unsigned REFRESHES   = 4096,
  parameter int unsigned TRRC_NS     = 70,
  parameter int unsigned TSRE_CLKS   = 1,
  parameter int unsigned BACKLOG_MAX = 8,
  parameter int unsigned RST_STAGES  = 2,
  localparam int unsigned CW = $clog2(BACKLOG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_ack_i,
  input  logic          sr_enter_i,
  input  logic          sr_exit_i,
  output logic          ref_req_o,
  output logic          ref_urgent_o,
  output logic [CW-1:0] backlog_o,
  output logic          cmd_ok_o,
  output logic          self_ref_o
);
  localparam int unsigned INTERVAL_CLKS = interval_clks(CLK_HZ, WINDOW_MS, REFRESHES);
  localparam int unsigned TRRC_CLKS     = ns_to_clks(CLK_HZ, TRRC_NS);

  // Reset: asserted at once, released after RST_STAGES clocks.
  logic [RST_STAGES-1:0] rsync_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[RST_STAGES-1];

  rs_mode_e mode_q, mode_d;
  logic     quiet, tick, pending;
  logic     enter_ok, ack_ok, exit_ok, running;

  always_comb begin
    running  = (mode_q == MODE_RUN);
    enter_ok = running && quiet && sr_enter_i;
    ack_ok   = running && quiet && pending && ref_ack_i && !enter_ok;
    exit_ok  = (mode_q == MODE_SELF) && sr_exit_i;
    mode_d   = mode_q;
    if (enter_ok)     mode_d = MODE_SELF;
    else if (exit_ok) mode_d = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= MODE_RUN;
    else            mode_q <= mode_d;
  end

  refsched_interval #(
    .INTERVAL (INTERVAL_CLKS)
  ) u_interval (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_en  (running),
    .restart (enter_ok),
    .tick_o  (tick)
  );

  refsched_backlog #(
    .MAX (BACKLOG_MAX)
  ) u_backlog (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .take      (ack_ok),
    .flush     (enter_ok),
    .count_o   (backlog_o),
    .pending_o (pending),
    .urgent_o  (ref_urgent_o)
  );

  refsched_guard #(
    .TRRC_CLKS (TRRC_CLKS),
    .TSRE_CLKS (TSRE_CLKS)
  ) u_guard (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .after_ref  (ack_ok),
    .after_wake (exit_ok),
    .quiet_o    (quiet)
  );

  assign ref_req_o  = running && pending;
  assign cmd_ok_o   = running && quiet;
  assign self_ref_o = (mode_q == MODE_SELF);

  assert_self_silent_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    self_ref_o |-> (!ref_req_o && !cmd_ok_o));
  assert_entry_flush_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(self_ref_o) |-> (backlog_o == '0));
  assert_entry_gate_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!self_ref_o && !cmd_ok_o) |=> !self_ref_o);
  assert_stay_self_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (self_ref_o && !sr_exit_i) |=> self_ref_o);
  assert_exit_next_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (self_ref_o && sr_exit_i) |=> (!self_ref_o && !cmd_ok_o));

endmodule

// File: tb/sdram_refresh_scheduler_bench.sv
module sdram_refresh_scheduler_bench;
  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned WIN_MS = 64;
  localparam int unsigned NREF   = 4096;
  localparam int unsigned TRRC_N = 70;
  localparam int unsigned TSRE   = 1;
  localparam int unsigned BMAX   = 8;
  localparam int unsigned PER    = ((CLK_HZ / 1000) * WIN_MS) / NREF;
  localparam int unsigned TRRC   = (TRRC_N * (CLK_HZ / 1_000_000) + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n, ref_ack, sr_enter, sr_exit;
  logic ref_req, ref_urgent, cmd_ok, self_ref;
  logic [3:0] backlog;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int m_bl, m_hold, m_el;
  bit m_self;

  always #10 clk = ~clk;

  sdram_refresh_scheduler #(
    .CLK_HZ (CLK_HZ), .WINDOW_MS (WIN_MS), .REFRESHES (NREF),
    .TRRC_NS (TRRC_N), .TSRE_CLKS (TSRE), .BACKLOG_MAX (BMAX)
  ) u_sdram_refresh_scheduler (
    .clk (clk), .rst_n (rst_n), .ref_ack_i (ref_ack), .sr_enter_i (sr_enter),
    .sr_exit_i (sr_exit), .ref_req_o (ref_req), .ref_urgent_o (ref_urgent),
    .backlog_o (backlog), .cmd_ok_o (cmd_ok), .self_ref_o (self_ref)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(tag, "backlog", int'(backlog), m_self ? 0 : m_bl);
    chk(tag, "ref_req", int'(ref_req), (!m_self && m_bl > 0) ? 1 : 0);
    chk(tag, "urgent", int'(ref_urgent), (m_bl == BMAX) ? 1 : 0);
    chk(tag, "cmd_ok", int'(cmd_ok), (!m_self && m_hold == 0) ? 1 : 0);
    chk(tag, "self_ref", int'(self_ref), m_self ? 1 : 0);
  endtask

  // One clock: predict from the inputs in force at the coming edge.
  task automatic cyc();
    bit tk, ent, ack, ext;
    ent = !m_self && m_hold == 0 && sr_enter;
    ack = !m_self && m_hold == 0 && m_bl > 0 && ref_ack && !ent;
    ext = m_self && sr_exit;
    tk  = !m_self && (((m_el + 1) % PER) == 0);
    @(negedge clk);
    if (ent) begin
      m_bl = 0; m_el = 0; m_self = 1'b1;
    end else begin
      if (tk && !ack && m_bl < BMAX) m_bl++;
      if (ack && !tk) m_bl--;
      if (!m_self) m_el++;
    end
    if (ext) begin
      m_self = 1'b0; m_el = 0;
    end
    if (ext)            m_hold = TSRE + TRRC - 1;
    else if (ack)       m_hold = TRRC - 1;
    else if (m_hold > 0) m_hold--;
    check_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc();
    sig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_ack = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
    m_bl = 0; m_hold = 0; m_el = 0; m_self = 1'b0;
    repeat (3) @(negedge clk);
    check_all();                       // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all();                       // R1 across synchronous release

    tag = "R2"; run(PER * 7 + 3);
    tag = "R4"; run(PER + 20);
    chk("R4", "full backlog", int'(backlog), BMAX);
    chk("R4", "urgent flag", int'(ref_urgent), 1);

    tag = "R3"; pulse(ref_ack);
    chk("R3", "after one ack", int'(backlog), BMAX - 1);
    tag = "R6"; run(6);

    tag = "R5"; ref_ack = 1'b1; run(60); ref_ack = 1'b0;
    chk("R5", "drained backlog", int'(backlog), 0);
    run(5);

    tag = "R7";
    while (m_bl == 0) cyc();
    pulse(ref_ack);
    pulse(sr_enter);                   // during tRRC hold: ignored
    chk("R7", "entry while held", int'(self_ref), 0);
    while (m_bl == 0) cyc();
    run(5);
    pulse(sr_enter);
    chk("R7", "entered", int'(self_ref), 1);
    run(PER * 2 + 7);

    tag = "R9"; pulse(sr_enter); run(3);
    tag = "R8"; pulse(sr_exit);
    chk("R8", "left self-refresh", int'(self_ref), 0);
    run(PER + 10);
    tag = "R9"; pulse(sr_exit); run(3);

    tag = "R10";
    while (m_bl == 0 || m_hold != 0) cyc();
    ref_ack = 1'b1; sr_enter = 1'b1;
    cyc();
    ref_ack = 1'b0; sr_enter = 1'b0;
    chk("R10", "entry won", int'(self_ref), 1);
    run(3);
    tag = "R8"; pulse(sr_exit); run(PER + 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule